// File: doc/BRIEF.md
# UART Receive Character Queue with Level Interrupt

This block holds the characters a UART has received until software reads them. Each stored word carries eight data bits plus a framing-error bit, a parity-error bit and a line-break bit. Words arrive from one of two sources. The first is the line-side deserializer. The second is an internal loopback path from the transmitter. Words leave through reads of the data register. The block tracks a read position and an occupancy count. From these it drives full and empty flags and a free-space count that the upstream receiver uses as a ready indication. It raises a receive interrupt when the occupancy reaches a trigger level.

The queue has two modes, chosen at run time by a configuration bit. In queued mode it is 16 entries deep. In single-slot mode it holds one entry. Changing the mode discards whatever is held. A line break is stored as a word of zero data with the break bit set. Each read loads a small error-status register from the error bits of the word just read.

Top module: `uart_rxq`

## Requirements
- R1: After a synchronous active-low reset, in single-slot mode: `empty`=1, `full`=0, `free_space`=1, `rx_irq`=0, `irq_upd`=0, `ovr`=0, `err_stat`=0.
- R2: In queued mode (`cfg_fifo_en`=1) up to 16 words are returned in arrival order. `full` is 1 exactly when 16 words are held, `empty` is 1 exactly when none are held, and `free_space` equals 16 minus the occupancy.
- R3: In single-slot mode (`cfg_fifo_en`=0) one word fills the block (`full`=1, `free_space`=0). A further word is dropped, sets `ovr`, and leaves the held word in place.
- R4: In queued mode a word that arrives while 16 words are held (and no read happens in that cycle) is dropped, sets `ovr`, and leaves the held words intact.
- R5: When `cfg_fifo_en` differs from its value in the previous cycle, the block is emptied at the next edge. Occupancy becomes 0, `empty`=1 and `free_space` becomes the new depth. `rx_irq` keeps its value.
- R6: A word that brings the occupancy to the trigger level (1) sets `rx_irq` at the same edge. `irq_upd` is high for exactly that one following cycle.
- R7: A read that leaves the occupancy one below the trigger level (that is, 0) clears `rx_irq`.
- R8: A read while empty leaves occupancy 0 and the flags unchanged, apart from the interrupt rule of R7.
- R9: `rd_data` is laid out as [7:0] data, [8] framing, [9] parity, [10] break. Each read loads `err_stat` with {break, parity, framing} of the word read (bits 2,1,0). `st_clr` clears both `err_stat` and `ovr`.
- R10: `rx_brk` stores a word with data 0 and the break bit set. It takes precedence over `rx_vld` in the same cycle, and that line data is not stored.
- R11: While `lb_en`=1, `rx_vld` and `rx_brk` have no effect. `lb_vld` stores `lb_data` with no error bits, and `lb_brk` stores a break word.
- R12: A read and a write in the same cycle act as read first, then write. On a full queue both are accepted with no overrun. At occupancy 1, `rx_irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fifo_en | input | 1 | 1 = 16-entry queued mode, 0 = single slot |
| lb_en | input | 1 | Loopback active; line inputs ignored |
| rx_vld | input | 1 | Line-side word strobe |
| rx_data | input | 8 | Line-side data |
| rx_frm | input | 1 | Line-side framing error |
| rx_par | input | 1 | Line-side parity error |
| rx_brk | input | 1 | Line-side break detected |
| lb_vld | input | 1 | Loopback word strobe |
| lb_data | input | 8 | Loopback data |
| lb_brk | input | 1 | Loopback break |
| rd_en | input | 1 | Data-register read strobe |
| st_clr | input | 1 | Error-status clear strobe |
| rd_data | output | 11 | Word from the last read |
| err_stat | output | 3 | {break, parity, framing} of the last word read |
| ovr | output | 1 | Sticky overrun |
| full | output | 1 | Occupancy equals effective depth |
| empty | output | 1 | Occupancy is zero |
| free_space | output | 5 | Effective depth minus occupancy |
| rx_irq | output | 1 | Receive level interrupt |
| irq_upd | output | 1 | One-cycle pulse when a write sets the interrupt |

## Verification
A bus read and an arriving character can fall in the same cycle. The bench provokes this twice. The first time is on a full 16-entry queue, where the write must be accepted with no overrun. The second time is at occupancy one in single-slot mode, where the interrupt is cleared and then set again within the same cycle. In both cases the scoreboard judges the outcome by applying the read before the write. It compares the word returned, the flags, the free space and the interrupt against that order.

// File: rtl/uart_rxq_pkg.sv
// Shared word layout of the receive queue.
// Assumes 8-bit characters; error bits sit above the data byte.
package uart_rxq_pkg;
    localparam int DW = 8;

    typedef struct packed {
        logic          brk;
        logic          par;
        logic          frm;
        logic [DW-1:0] data;
    } rxq_word_t;

    localparam int WW = $bits(rxq_word_t);
endpackage

// File: rtl/uart_rxq_src.sv
// Source selector: picks which incoming character is written this cycle.
// Assumes at most one write per cycle. A break beats data. Loopback
// disconnects the line inputs completely.
module uart_rxq_src
    import uart_rxq_pkg::*;
(
    input  logic          lb_en,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_frm,
    input  logic          rx_par,
    input  logic          rx_brk,
    input  logic          lb_vld,
    input  logic [DW-1:0] lb_data,
    input  logic          lb_brk,
    output logic          push,
    output rxq_word_t     word
);
    // Select the write source and build the stored word.
    always_comb begin
        push = 1'b0;
        word = '0;
        if (lb_en) begin
            if (lb_brk) begin
                push     = 1'b1;
                word.brk = 1'b1;
            end else if (lb_vld) begin
                push      = 1'b1;
                word.data = lb_data;
            end
        end else begin
            if (rx_brk) begin
                push     = 1'b1;
                word.brk = 1'b1;
            end else if (rx_vld) begin
                push      = 1'b1;
                word.data = rx_data;
                word.frm  = rx_frm;
                word.par  = rx_par;
            end
        end
    end
endmodule

// File: rtl/uart_rxq_ctl.sv
// Occupancy and read-position control.
// Assumes DEPTH is a power of two and at least 2. The effective depth is
// DEPTH or 1. A read is applied before a write in the same cycle. A flush
// overrides all traffic in its cycle.
module uart_rxq_ctl #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    output logic          wr_we,
    output logic [AW-1:0] wr_slot,
    output logic [AW-1:0] rd_slot,
    output logic          pop_ok,
    output logic          drop,
    output logic [CW-1:0] occ_mid,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] free_space
);
    logic [CW-1:0] count_q;
    logic [CW-1:0] depth_eff;
    logic [AW-1:0] rptr_q;
    logic [AW-1:0] rptr_nx;
    logic [AW-1:0] mask;
    logic          pop_dec;
    logic          room;

    // Derive the effective depth, the read-first occupancy and the write slot.
    always_comb begin
        depth_eff = fifo_mode ? CW'(DEPTH) : CW'(1);
        mask      = fifo_mode ? AW'(DEPTH - 1) : '0;
        pop_ok    = pop && !flush;
        pop_dec   = pop_ok && (count_q != '0);
        occ_mid   = count_q - CW'(pop_dec);
        rptr_nx   = pop_dec ? ((rptr_q + AW'(1)) & mask) : rptr_q;
        room      = occ_mid < depth_eff;
        wr_we     = push && !flush && room;
        drop      = push && !flush && !room;
        wr_slot   = (rptr_nx + occ_mid[AW-1:0]) & mask;
    end

    // Advance occupancy and read position; flush or reset empties.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count_q <= '0;
            rptr_q  <= '0;
        end else begin
            count_q <= occ_mid + CW'(wr_we);
            rptr_q  <= rptr_nx;
        end
    end

    // Status derived from the registered occupancy.
    always_comb begin
        rd_slot    = rptr_q;
        full       = (count_q == depth_eff);
        empty      = (count_q == '0);
        free_space = depth_eff - count_q;
    end
endmodule

// File: rtl/uart_rxq_store.sv
// Word storage: one register per slot, a single write port and a
// combinational read port. Assumes the write slot is in range.
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wslot,
    input  rxq_word_t     wword,
    input  logic [AW-1:0] rslot,
    output rxq_word_t     rword
);
    rxq_word_t ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the written word into this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (we && (wslot == AW'(g))) begin
                ent[g] <= wword;
            end
        end
    end

    // Present the word at the read position.
    always_comb rword = ent[rslot];
endmodule

// File: rtl/uart_rxq_irq.sv
// Receive level interrupt. It reacts only when the occupancy crosses the
// trigger level exactly. Assumes occ_mid is the occupancy after this
// cycle's read and before its write.
module uart_rxq_irq #(
    parameter int CW   = 5,
    parameter int TRIG = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_ok,
    input  logic          pop_ok,
    input  logic [CW-1:0] occ_mid,
    output logic          irq,
    output logic          upd
);
    logic hit;
    logic set;
    logic clr;

    // Detect the exact crossing of the trigger level.
    always_comb begin
        hit = (occ_mid + CW'(1)) == CW'(TRIG);
        set = push_ok && hit;
        clr = pop_ok && hit;
    end

    // Hold the interrupt; a setting write wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            upd <= 1'b0;
        end else begin
            upd <= set;
            if (set) begin
                irq <= 1'b1;
            end else if (clr) begin
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_rxq.sv
// Top: receive character queue with mode-dependent depth and a level
// interrupt. Assumes read and clear strobes last one cycle each. Changing
// the mode empties the queue at the next edge.
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fifo_en,
    input  logic          lb_en,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_frm,
    input  logic          rx_par,
    input  logic          rx_brk,
    input  logic          lb_vld,
    input  logic [DW-1:0] lb_data,
    input  logic          lb_brk,
    input  logic          rd_en,
    input  logic          st_clr,
    output logic [WW-1:0] rd_data,
    output logic [2:0]    err_stat,
    output logic          ovr,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] free_space,
    output logic          rx_irq,
    output logic          irq_upd
);
    logic          mode_q;
    logic          flush;
    logic          push;
    rxq_word_t     pword;
    rxq_word_t     rword;
    logic          wr_we;
    logic [AW-1:0] wr_slot;
    logic [AW-1:0] rd_slot;
    logic          pop_ok;
    logic          drop;
    logic [CW-1:0] occ_mid;

    // Track the active mode; a change requests a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= cfg_fifo_en;
    end
    always_comb flush = (cfg_fifo_en != mode_q);

    uart_rxq_src u_src (
        .lb_en  (lb_en),
        .rx_vld (rx_vld),
        .rx_data(rx_data),
        .rx_frm (rx_frm),
        .rx_par (rx_par),
        .rx_brk (rx_brk),
        .lb_vld (lb_vld),
        .lb_data(lb_data),
        .lb_brk (lb_brk),
        .push   (push),
        .word   (pword)
    );

    uart_rxq_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (mode_q),
        .flush     (flush),
        .push      (push),
        .pop       (rd_en),
        .wr_we     (wr_we),
        .wr_slot   (wr_slot),
        .rd_slot   (rd_slot),
        .pop_ok    (pop_ok),
        .drop      (drop),
        .occ_mid   (occ_mid),
        .full      (full),
        .empty     (empty),
        .free_space(free_space)
    );

    uart_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_we),
        .wslot(wr_slot),
        .wword(pword),
        .rslot(rd_slot),
        .rword(rword)
    );

    uart_rxq_irq #(.CW(CW), .TRIG(TRIG)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_ok(wr_we),
        .pop_ok (pop_ok),
        .occ_mid(occ_mid),
        .irq    (rx_irq),
        .upd    (irq_upd)
    );

    // Latch the word read and its error bits; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            err_stat <= '0;
        end else if (pop_ok) begin
            rd_data  <= rword;
            err_stat <= {rword.brk, rword.par, rword.frm};
        end else if (st_clr) begin
            err_stat <= '0;
        end
    end

    // Sticky overrun on a dropped word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ovr <= 1'b0;
        else if (drop)   ovr <= 1'b1;
        else if (st_clr) ovr <= 1'b0;
    end
endmodule

// File: rtl/uart_rxq_chk.sv
// Property checker for uart_rxq, attached by bind.
module uart_rxq_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_fifo_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] free_space,
    input logic          rx_irq,
    input logic          irq_upd,
    input logic          ovr
);
    logic armed;

    // Mark cycles whose previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R2
    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        free_space <= CW'(DEPTH)); // R2
    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cfg_fifo_en && !$past(cfg_fifo_en)) |-> (free_space <= CW'(1))); // R3
    AST_OVR_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full)); // R4
    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (cfg_fifo_en != $past(cfg_fifo_en))) |=> empty); // R5
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> irq_upd); // R6
    AST_IRQ_DROP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq) |-> $past(rd_en)); // R7
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_fifo_en(cfg_fifo_en),
    .rd_en      (rd_en),
    .full       (full),
    .empty      (empty),
    .free_space (free_space),
    .rx_irq     (rx_irq),
    .irq_upd    (irq_upd),
    .ovr        (ovr)
);

// File: tb/sim_uart_rxq.sv
`timescale 1ns/1ps
module sim_uart_rxq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_en = 1'b0, lb_en = 1'b0;
    logic        rx_vld = 1'b0, rx_frm = 1'b0, rx_par = 1'b0, rx_brk = 1'b0;
    logic [7:0]  rx_data = '0, lb_data = '0;
    logic        lb_vld = 1'b0, lb_brk = 1'b0, rd_en = 1'b0, st_clr = 1'b0;
    logic [10:0] rd_data;
    logic [2:0]  err_stat;
    logic        ovr, full, empty, rx_irq, irq_upd;
    logic [4:0]  free_space;

    int n_chk = 0;
    int n_fail = 0;
    int depth_m = 1;
    bit exp_irq = 1'b0;
    bit exp_ovr = 1'b0;
    logic [10:0] q [$];
    logic [10:0] mon_w;

    always #2.5 clk = ~clk;

    uart_rxq u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(empty == (q.size() == 0), {req, " empty"}, int'(empty), int'(q.size() == 0));
        chk(full == (q.size() == depth_m), {req, " full"}, int'(full), int'(q.size() == depth_m));
        chk(free_space == 5'(depth_m - q.size()), {req, " free_space"}, int'(free_space), depth_m - q.size());
        chk(rx_irq == exp_irq, {req, " rx_irq"}, int'(rx_irq), int'(exp_irq));
        chk(ovr == exp_ovr, {req, " ovr"}, int'(ovr), int'(exp_ovr));
    endtask

    // Driver: model one edge (read first, then write), then release strobes.
    task automatic tick(input bit exp_push, input logic [10:0] w);
        int sz0 = q.size();
        int c1 = (rd_en && sz0 > 0) ? sz0 - 1 : sz0;
        bit acc = exp_push && (c1 < depth_m);
        if (acc && c1 == 0) exp_irq = 1'b1;
        else if (rd_en && c1 == 0) exp_irq = 1'b0;
        if (exp_push && !acc) exp_ovr = 1'b1;
        if (st_clr && !(exp_push && !acc)) exp_ovr = 1'b0;
        @(posedge clk);
        #1;
        if (acc) q.push_back(w);
        @(negedge clk);
        rx_vld = 0; rx_brk = 0; lb_vld = 0; lb_brk = 0; rd_en = 0; st_clr = 0;
        rx_frm = 0; rx_par = 0;
    endtask

    // Monitor: on each effective read, compare the returned word (R2, R9).
    always begin
        @(posedge clk);
        if (rst_n && rd_en && q.size() > 0) begin
            mon_w = q.pop_front();
            #1;
            chk(rd_data == mon_w, "R2 rd_data order", int'(rd_data), int'(mon_w));
            chk(err_stat == mon_w[10:8], "R9 err_stat load", int'(err_stat), int'(mon_w[10:8]));
        end
    end

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_state("R1");
        chk(err_stat == 0, "R1 err_stat", int'(err_stat), 0);
        chk(irq_upd == 0, "R1 irq_upd", int'(irq_upd), 0);

        // Single-slot mode
        rx_vld = 1; rx_data = 8'hA5; rx_frm = 1;
        tick(1, {3'b001, 8'hA5});
        chk_state("R3 one held");
        chk(irq_upd == 1, "R6 pulse", int'(irq_upd), 1);
        rx_vld = 1; rx_data = 8'h3C;
        tick(1, {3'b000, 8'h3C});
        chk_state("R3 dropped");
        chk(irq_upd == 0, "R6 single pulse", int'(irq_upd), 0);
        rd_en = 1;
        tick(0, '0);
        chk_state("R7 read clears");
        st_clr = 1;
        tick(0, '0);
        chk(err_stat == 0, "R9 clear", int'(err_stat), 0);
        chk_state("R9 clear");

        // Queued mode
        cfg_fifo_en = 1;
        tick(0, '0);
        q.delete(); depth_m = 16;
        chk_state("R5 enter queued");
        for (int i = 0; i < 16; i++) begin
            rx_vld = 1; rx_data = 8'(i * 17 + 3); rx_frm = i[0]; rx_par = i[1];
            tick(1, {1'b0, 1'(i >> 1), 1'(i), 8'(i * 17 + 3)});
        end
        chk_state("R2 full");
        rx_vld = 1; rx_data = 8'hEE;
        tick(1, {3'b000, 8'hEE});
        chk_state("R4 overrun");
        st_clr = 1;
        tick(0, '0);
        rx_vld = 1; rx_data = 8'h5A; rd_en = 1;
        tick(1, {3'b000, 8'h5A});
        chk_state("R12 full read+write");
        while (q.size() > 0) begin
            rd_en = 1;
            tick(0, '0);
        end
        chk_state("R2 drained");

        // Break precedence
        rx_brk = 1; rx_vld = 1; rx_data = 8'h77;
        tick(1, {3'b100, 8'h00});
        chk_state("R10 one break word");
        rd_en = 1;
        tick(0, '0);
        chk(err_stat == 3'b100, "R10 break status", int'(err_stat), 4);

        // Loopback
        lb_en = 1;
        rx_vld = 1; rx_data = 8'h11;
        tick(0, '0);
        chk_state("R11 line data ignored");
        rx_brk = 1;
        tick(0, '0);
        chk_state("R11 line break ignored");
        lb_vld = 1; lb_data = 8'hC3;
        tick(1, {3'b000, 8'hC3});
        lb_brk = 1;
        tick(1, {3'b100, 8'h00});
        chk_state("R11 loopback stored");
        lb_en = 0;

        // Mode change with content and interrupt set
        cfg_fifo_en = 0;
        tick(0, '0);
        q.delete(); depth_m = 1;
        chk_state("R5 flush keeps irq");

        // Read while empty
        rd_en = 1;
        tick(0, '0);
        chk_state("R8 empty read");

        // Read+write at occupancy one
        rx_vld = 1; rx_data = 8'h42;
        tick(1, {3'b000, 8'h42});
        rx_vld = 1; rx_data = 8'h24; rd_en = 1;
        tick(1, {3'b000, 8'h24});
        chk_state("R12 occupancy one");
        chk(irq_upd == 1, "R12 irq re-set pulse", int'(irq_upd), 1);
        rd_en = 1;
        tick(0, '0);
        chk_state("R7 final read");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule